// File: doc/BRIEF.md
# Prescaled Interval Timer with Interrupt

An 8-bit interval timer that counts down from a value written by the CPU. The write address also carries the settings. Its two low bits pick one of four prescale ratios, and a higher bit sets whether the timer may interrupt. The data byte becomes the starting count. Each time the prescaler completes a period, the count drops by one. When the count wraps from zero to all ones, an expiry flag is raised. From then on the counter steps once per clock, whatever ratio was selected. Software can therefore read how far the timer has overshot.

The CPU side is a register port with no handshake. A write strobe loads the timer. A read strobe marks an access to one of two registers, picked by a select bit: the count or the flag. The read data follows the select bit at all times, and the strobe only carries the side effect of the access. A read access of the count clears the flag. An active-low interrupt output is driven low while the flag is set and interrupts are enabled.

Top module: `pit_timer`

## Requirements
- R1: After reset the count is 0xFF, the flag is clear, `irq_n` is high and the ratio is 1024, so the count first becomes 0xFE on the 1024th clock after reset is released.
- R2: A write loads `wr_data` into the count, clears the flag and restarts the prescaler, so the first decrement comes one full prescale period after the write clock.
- R3: `wr_addr[1:0]` selects the ratio of a write: 0 gives 1, 1 gives 8, 2 gives 64 and 3 gives 1024 clocks per decrement.
- R4: Once the count has wrapped from 0x00 to 0xFF, it decrements on every clock until the next write and keeps wrapping. A read of the count returns the low byte.
- R5: The flag is set on the clock where the count wraps from 0x00 to 0xFF. With `rd_sel`=1, `rd_data` returns the flag in bit 7 and zeros in bits 6..0.
- R6: A count read access (`rd_en`=1 with `rd_sel`=0) clears the flag. A flag read access (`rd_en`=1 with `rd_sel`=1) leaves it unchanged.
- R7: `wr_addr[3]` of a write sets the interrupt enable (1 enables). `irq_n` is low exactly while the flag is set and the enable is 1.
- R8: If a wrap and a count read access fall on the same clock, the flag ends set. If a wrap and a write fall on the same clock, the write wins: the count is the new value and the flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe that loads the timer |
| wr_addr | input | 4 | Write address: [1:0] selects the ratio, [3] is the interrupt enable |
| wr_data | input | 8 | Start value for the count |
| rd_en | input | 1 | Read access strobe (carries the flag-clear side effect) |
| rd_sel | input | 1 | 0 selects the count, 1 selects the flag register |
| rd_data | output | 8 | Selected register value |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The flag has three sources that can meet on one clock edge: the wrap that sets it, the count read access that clears it, and the write that clears it. The bench computes the exact clock of the wrap from the loaded value and the ratio. It places a count read access on that same edge and checks that the flag is set afterwards. In a separate run it places a new write on a wrap edge and checks that the new value is loaded, the flag is clear, and the next decrement follows the newly selected ratio.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int PS_W    = 10;
    localparam int SEL_LSB = 0;
    localparam int IE_BIT  = 3;

    typedef enum logic [1:0] {
        DIV_1    = 2'd0,
        DIV_8    = 2'd1,
        DIV_64   = 2'd2,
        DIV_1024 = 2'd3
    } div_sel_e;

    typedef struct packed {
        div_sel_e sel;
        logic     irq_en;
    } tmr_ctrl_t;

    function automatic int unsigned shift_of(div_sel_e s);
        case (s)
            DIV_1:   return 0;
            DIV_8:   return 3;
            DIV_64:  return 6;
            default: return 10;
        endcase
    endfunction

    function automatic logic [PS_W-1:0] period_mask(div_sel_e s);
        logic [PS_W:0] one_hot;
        one_hot = (PS_W+1)'(1) << shift_of(s);
        return PS_W'(one_hot - 1'b1);
    endfunction

endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler
    import pit_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     restart,
    input  logic     fast,
    input  div_sel_e sel,
    output logic     tick
);
    logic [PS_W-1:0] ps_q;
    logic            hit;

    assign hit  = (ps_q == period_mask(sel));
    assign tick = fast | hit;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            ps_q <= '0;
        end else if (hit) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_q + 1'b1;
        end
    end
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             fast,
    output logic             underflow
);
    localparam logic [CNT_W-1:0] RST_CNT = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             fast_q;

    assign underflow = tick && !load && (cnt_q == '0);
    assign cnt       = cnt_q;
    assign fast      = fast_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= RST_CNT;
            fast_q <= 1'b0;
        end else if (load) begin
            cnt_q  <= load_val;
            fast_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == '0) begin
                fast_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pit_ctrl.sv
module pit_ctrl
    import pit_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              underflow,
    input  logic              cnt_read,
    output div_sel_e          sel,
    output logic              irq_en,
    output logic              flag
);
    tmr_ctrl_t ctrl_q;
    logic      flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.sel    <= DIV_1024;
            ctrl_q.irq_en <= 1'b0;
        end else if (wr_en) begin
            ctrl_q.sel    <= div_sel_e'(wr_addr[SEL_LSB +: 2]);
            ctrl_q.irq_en <= wr_addr[IE_BIT];
        end
    end

    // Priority: write clears, wrap sets, count read clears.
    always_ff @(posedge clk) begin
        if (rst || wr_en) begin
            flag_q <= 1'b0;
        end else if (underflow) begin
            flag_q <= 1'b1;
        end else if (cnt_read) begin
            flag_q <= 1'b0;
        end
    end

    assign sel    = ctrl_q.sel;
    assign irq_en = ctrl_q.irq_en;
    assign flag   = flag_q;
endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic              rd_sel,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq_n
);
    localparam int LOW_BITS = CNT_W - 1;

    logic             tick;
    logic             fast;
    logic             underflow;
    logic [CNT_W-1:0] cnt;
    div_sel_e         sel;
    logic             irq_en;
    logic             flag;
    logic             cnt_read;

    assign cnt_read = rd_en && !rd_sel;

    pit_prescaler u_pres (
        .clk     (clk),
        .rst     (rst),
        .restart (wr_en),
        .fast    (fast),
        .sel     (sel),
        .tick    (tick)
    );

    pit_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .load      (wr_en),
        .load_val  (wr_data),
        .tick      (tick),
        .cnt       (cnt),
        .fast      (fast),
        .underflow (underflow)
    );

    pit_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .underflow (underflow),
        .cnt_read  (cnt_read),
        .sel       (sel),
        .irq_en    (irq_en),
        .flag      (flag)
    );

    assign rd_data = rd_sel ? {flag, {LOW_BITS{1'b0}}} : cnt;
    assign irq_n   = !(flag && irq_en);
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]  wr_data,
    input logic              rd_en,
    input logic              rd_sel,
    input logic [CNT_W-1:0]  rd_data,
    input logic              irq_n,
    input logic [CNT_W-1:0]  cnt,
    input logic              flag,
    input logic              fast,
    input logic              tick
);
    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cnt == $past(wr_data)) && !flag);

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !tick) |=> $stable(cnt));

    assert_fast_R4: assert property (@(posedge clk) disable iff (rst)
        (fast && !wr_en) |=> cnt == CNT_W'($past(cnt) - 1'b1));

    assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && tick && cnt == '0) |=> flag && (cnt == '1));

    assert_flag_bits_R5: assert property (@(posedge clk) disable iff (rst)
        rd_sel |-> rd_data[CNT_W-2:0] == '0);

    assert_read_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_sel && !wr_en && !(tick && cnt == '0)) |=> !flag);

    assert_irq_off_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_addr[3]) |=> irq_n);
endmodule

bind pit_timer pit_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_sel  (rd_sel),
    .rd_data (rd_data),
    .irq_n   (irq_n),
    .cnt     (cnt),
    .flag    (flag),
    .fast    (fast),
    .tick    (tick)
);

// File: tb/pit_timer_tb_top.sv
`timescale 1ns/1ps
module pit_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    pit_timer dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_data(rd_data), .irq_n(irq_n)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Look at count, flag register and irq without an access strobe.
    task automatic peek(output int c, output int f, output int i);
        rd_sel = 1'b0; #0.5; c = rd_data;
        rd_sel = 1'b1; #0.5; f = rd_data; i = irq_n;
        rd_sel = 1'b0;
    endtask

    function automatic int div_of(int sel);
        case (sel)
            0: return 1;
            1: return 8;
            2: return 64;
            default: return 1024;
        endcase
    endfunction

    function automatic int exp_cnt(int n, int d, int j);
        if (j < (n + 1) * d) return n - j / d;
        return (255 - (j - (n + 1) * d)) & 255;
    endfunction

    // Called at a negedge; returns at the negedge after the write edge.
    task automatic do_load(int sel, bit ie, int n);
        wr_en = 1'b1; wr_addr = {ie, 1'b0, sel[1:0]}; wr_data = n[7:0];
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Check j = 0..len clocks after the load edge; no reads in between.
    task automatic track(int n, int d, bit ie, int len, string tag);
        int c, f, i, ef;
        for (int j = 0; j <= len; j++) begin
            peek(c, f, i);
            ef = (j >= (n + 1) * d) ? 128 : 0;
            chk({tag, " count"}, c, exp_cnt(n, d, j));
            chk({tag, " flag R5"}, f, ef);
            chk({tag, " irq R7"}, i, (ef != 0 && ie) ? 0 : 1);
            if (j != len) @(negedge clk);
        end
    endtask

    initial begin
        int c, f, i;
        int ns [4];
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset defaults, ratio 1024
        track(255, 1024, 1'b0, 1100, "R1 reset");

        // R2/R3/R4/R5/R7: sweep ratios and start values
        for (int sel = 0; sel < 4; sel++) begin
            case (sel)
                0: ns = '{0, 1, 2, 255};
                1: ns = '{0, 1, 7, 255};
                2: ns = '{0, 1, 7, 40};
                default: ns = '{0, 1, 3, 3};
            endcase
            for (int k = 0; k < 4; k++) begin
                bit ie;
                ie = ns[k][0] ^ sel[0];
                @(negedge clk);
                do_load(sel, ie, ns[k]);
                track(ns[k], div_of(sel), ie,
                      (ns[k] + 1) * div_of(sel) + 300, "R2 R3 R4 sweep");
            end
        end

        // R6: flag read access keeps flag, count read access clears it
        @(negedge clk);
        do_load(0, 1'b1, 3);
        repeat (10) @(negedge clk);
        rd_sel = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        peek(c, f, i);
        chk("R6 flag read keeps flag", f, 128);
        chk("R7 irq low while flag", i, 0);
        rd_sel = 1'b0; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        peek(c, f, i);
        chk("R6 count read clears flag", f, 0);
        chk("R7 irq released", i, 1);
        // j now 12: underflow at j=4, count = 255-8 = 247; next wrap at j=260
        chk("R4 fast count value", c, 247);
        repeat (247) @(negedge clk);
        peek(c, f, i);
        chk("R4 count before rewrap", c, 0);
        chk("R5 flag before rewrap", f, 0);
        @(negedge clk);
        peek(c, f, i);
        chk("R4 rewrap count", c, 255);
        chk("R5 rewrap sets flag", f, 128);

        // R8: count read access on the wrap edge -> flag set
        @(negedge clk);
        do_load(1, 1'b1, 1);
        repeat (15) @(negedge clk);
        rd_sel = 1'b0; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        peek(c, f, i);
        chk("R8 read on wrap count", c, 255);
        chk("R8 read on wrap flag", f, 128);
        chk("R8 read on wrap irq", i, 0);

        // R8: write on the wrap edge -> write wins
        @(negedge clk);
        do_load(0, 1'b1, 2);
        repeat (2) @(negedge clk);
        do_load(2, 1'b0, 8'h50);
        track(8'h50, 64, 1'b0, 200, "R8 write on wrap");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles >= 150000);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule